// File: doc/BRIEF.md
# Dual-Processor Doorbell Channel Controller

This block lets two processors signal each other through a set of single-bit doorbell channels. Each processor owns a bank of outgoing flags. Ringing a doorbell marks one of the processor's own channels as occupied. The other processor sees the flag, handles the event and then frees the channel from its side. This hands ownership of the channel back to the sender, who can then ring again.

Both processors reach the block over one synchronous register bus. A select input identifies which processor drives the current access. Each processor has a register group at a fixed 0x10 stride: a command register and a status register. A shared read-only word reports how many channels are built. Each processor also gets a level interrupt while any doorbell from its peer is pending, and a one-cycle pulse when one of its own channels is freed.

Top module: `dbell_ctrl`

## Requirements
- R1: After reset every channel flag of both processors is free, both receive interrupts are low, both free pulses are low and a status read returns 0.
- R2: When processor p writes 1 to bit 16+n of its command word, its channel n becomes occupied. The command word of processor p sits at byte offset 0x008 + 0x10*p. The status word of processor p sits at 0x00C + 0x10*p and shows channel n in bit n.
- R3: When processor p writes 1 to bit n of its own command word, channel n of the other processor's status becomes free. The writer's own flags are left unchanged.
- R4: Writing 0 to a command bit changes nothing, and the command word always reads back as 0.
- R5: Channel bits at or above the NUM_CH parameter (1 to 16) are ignored on write and read as 0 in a status word.
- R6: The word at offset 0x3F0 returns NUM_CH in bits 7:0 and 0 in all other bits. Writes to it have no effect.
- R7: Offsets other than the five defined words read as 0. Writes to them, and writes to a status word, have no effect.
- R8: A write to a command word is accepted only when the processor select (0 or 1) matches that word's register group. Otherwise the write is ignored. Reads of any defined word are open to both processors.
- R9: Read data is returned in the cycle after the read strobe, flagged by a one-cycle valid.
- R10: The receive interrupt of processor p is high exactly while at least one channel of the other processor is occupied.
- R11: The free pulse of processor p is high for one cycle, starting in the cycle in which the flags show the release. It fires only when a write frees at least one of p's occupied channels. Freeing channels that are already free gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cpu | input | 1 | Processor driving the current access (0 or 1) |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| rx_irq | output | 2 | Per-processor level interrupt, peer doorbell pending |
| tx_free | output | 2 | Per-processor pulse, own channel released |

## Verification
Three kinds of sweep are run with a five-channel build. The first rings each single channel from each side, running past the channel count. This separates correct bit placement from off-by-one or wrong-side updates, and shows that bits above the count are dropped. The second occupies every 5-bit pattern and frees it with a different mask. This separates a correct set-then-free update from OR or XOR mixups, and shows whether the free pulse needs a channel that was really occupied. Directed writes then cover zero bits, the wrong processor, read-only words and unmapped words. Each of these must leave the visible flags untouched.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int unsigned ADDR_W     = 12;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned N_PROC     = 2;
    localparam int unsigned TX_SHIFT   = 16;
    localparam int unsigned CFG_CNT_W  = 8;

    localparam logic [ADDR_W-1:0] GRP_STRIDE = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_CMD    = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 12'h3F0;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_CMD  = 2'd1,
        RK_STAT = 2'd2,
        RK_CFG  = 2'd3
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e kind;
        logic      grp;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } rsp_t;

endpackage

// File: rtl/dbell_addr_dec.sv
module dbell_addr_dec
    import dbell_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    always_comb begin
        dec.kind = RK_NONE;
        dec.grp  = 1'b0;
        if (addr == OFS_CFG) begin
            dec.kind = RK_CFG;
        end
        for (int i = 0; i < int'(N_PROC); i++) begin
            if (addr == ADDR_W'(i) * GRP_STRIDE + OFS_CMD) begin
                dec.kind = RK_CMD;
                dec.grp  = 1'(i);
            end
            if (addr == ADDR_W'(i) * GRP_STRIDE + OFS_STAT) begin
                dec.kind = RK_STAT;
                dec.grp  = 1'(i);
            end
        end
    end

endmodule

// File: rtl/dbell_chan_bank.sv
module dbell_chan_bank #(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_mask,
    input  logic [NUM_CH-1:0] clr_mask,
    output logic [NUM_CH-1:0] flags_o,
    output logic              freed_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] flags;
        logic              freed;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        // set wins over clear on the same bit
        st_d.flags = (st_q.flags & ~clr_mask) | set_mask;
        st_d.freed = |(st_q.flags & ~st_d.flags);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;
    assign freed_o = st_q.freed;

endmodule

// File: rtl/dbell_ctrl.sv
module dbell_ctrl
    import dbell_pkg::*;
#(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cpu,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic [1:0]        rx_irq,
    output logic [1:0]        tx_free
);

    dec_t               dec;
    logic [N_PROC-1:0]  own_wr;
    logic [NUM_CH-1:0]  set_mask [N_PROC];
    logic [NUM_CH-1:0]  clr_mask [N_PROC];
    logic [NUM_CH-1:0]  flags    [N_PROC];
    logic [NUM_CH-1:0]  flags_p0, flags_p1;
    logic [DATA_W-1:0]  rd_word;
    rsp_t               rsp_d, rsp_q;
    logic               unused_wbits;

    dbell_addr_dec u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    for (genvar p = 0; p < int'(N_PROC); p++) begin : g_proc
        assign own_wr[p] = bus_wr && (dec.kind == RK_CMD) &&
                           (dec.grp == 1'(p)) && (bus_cpu == 1'(p));
        assign set_mask[p] = own_wr[p] ? bus_wdata[TX_SHIFT +: NUM_CH] : '0;
        assign clr_mask[p] = own_wr[1-p] ? bus_wdata[NUM_CH-1:0] : '0;

        dbell_chan_bank #(.NUM_CH(NUM_CH)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_mask (set_mask[p]),
            .clr_mask (clr_mask[p]),
            .flags_o  (flags[p]),
            .freed_o  (tx_free[p])
        );

        assign rx_irq[p] = |flags[1-p];
    end

    assign flags_p0 = flags[0];
    assign flags_p1 = flags[1];

    assign unused_wbits = ^bus_wdata;

    always_comb begin
        rd_word = '0;
        unique case (dec.kind)
            RK_STAT: rd_word[NUM_CH-1:0]    = flags[dec.grp];
            RK_CFG:  rd_word[CFG_CNT_W-1:0] = CFG_CNT_W'(NUM_CH);
            default: rd_word = '0;
        endcase
    end

    always_comb begin
        rsp_d        = rsp_q;
        rsp_d.rvalid = bus_rd;
        rsp_d.rdata  = bus_rd ? rd_word : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign bus_rdata  = rsp_q.rdata;
    assign bus_rvalid = rsp_q.rvalid;

endmodule

// File: rtl/dbell_ctrl_chk.sv
module dbell_ctrl_chk #(
    parameter int unsigned NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cpu,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [11:0]       bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic [1:0]        tx_free,
    input logic [NUM_CH-1:0] flags0,
    input logic [NUM_CH-1:0] flags1
);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (flags0 == '0 && flags1 == '0 && tx_free == 2'b00));

    a_r2_p0_set_by_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags0 & ~$past(flags0))) |-> ($past(bus_wr) && $past(bus_cpu) == 1'b0));

    a_r8_p1_set_by_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags1 & ~$past(flags1))) |-> ($past(bus_wr) && $past(bus_cpu) == 1'b1));

    a_r3_p0_freed_by_peer: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flags0) & ~flags0)) |-> ($past(bus_wr) && $past(bus_cpu) == 1'b1));

    a_r3_p1_freed_by_peer: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flags1) & ~flags1)) |-> ($past(bus_wr) && $past(bus_cpu) == 1'b0));

    a_r11_pulse_p0_real_release: assert property (@(posedge clk) disable iff (!rst_n)
        tx_free[0] |-> (|($past(flags0) & ~flags0)));

    a_r11_pulse_p1_real_release: assert property (@(posedge clk) disable iff (!rst_n)
        tx_free[1] |-> (|($past(flags1) & ~flags1)));

    a_r9_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    a_r6_cfg_value: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && $past(bus_addr) == 12'h3F0) |-> (bus_rdata == 32'(NUM_CH)));

    a_r4_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && ($past(bus_addr) == 12'h008 || $past(bus_addr) == 12'h018))
        |-> (bus_rdata == 32'd0));

    a_r5_stat_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && ($past(bus_addr) == 12'h00C || $past(bus_addr) == 12'h01C))
        |-> ((bus_rdata >> NUM_CH) == 32'd0));

endmodule

bind dbell_ctrl dbell_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_cpu    (bus_cpu),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .tx_free    (tx_free),
    .flags0     (flags_p0),
    .flags1     (flags_p1)
);

// File: tb/tb_dbell_ctrl.sv
`timescale 1ns/1ps
module tb_dbell_ctrl;

    localparam int NCH = 5;
    localparam logic [31:0] ALL = (32'd1 << NCH) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cpu = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [1:0]  rx_irq;
    logic [1:0]  tx_free;

    int checks = 0;
    int errors = 0;
    logic [1:0] txf_seen;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    dbell_ctrl #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .rx_irq(rx_irq), .tx_free(tx_free)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic cpu, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_cpu = cpu; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        txf_seen = tx_free;
    endtask

    task automatic rd(input logic cpu, input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_cpu = cpu; bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
        chk("R9 rvalid", {31'd0, bus_rvalid}, 32'd1);
    endtask

    function automatic logic [11:0] cmd_of(input int p);
        return 12'(16 * p + 8);
    endfunction

    function automatic logic [11:0] stat_of(input int p);
        return 12'(16 * p + 12);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 rx_irq", {30'd0, rx_irq}, 32'd0);
        chk("R1 tx_free", {30'd0, tx_free}, 32'd0);
        rd(0, stat_of(0), v); chk("R1 stat0", v, 32'd0);
        rd(1, stat_of(1), v); chk("R1 stat1", v, 32'd0);

        // R9 valid is a single-cycle pulse
        @(negedge clk);
        chk("R9 rvalid drop", {31'd0, bus_rvalid}, 32'd0);

        // R6 configuration word
        rd(0, 12'h3F0, v); chk("R6 cfg", v, NCH);
        wr(1, 12'h3F0, 32'hFFFF_FFFF);
        rd(1, 12'h3F0, v); chk("R6 cfg after write", v, NCH);

        // R2 R3 R5 R10 R11 single-channel sweep from both sides
        for (int p = 0; p < 2; p++) begin
            for (int n = 0; n < NCH + 2; n++) begin
                logic [31:0] e;
                e = (n < NCH) ? (32'd1 << n) : 32'd0;
                wr(1'(p), cmd_of(p), 32'd1 << (16 + n));
                chk("R10 rx_irq peer", {31'd0, rx_irq[1-p]}, {31'd0, (n < NCH)});
                chk("R10 rx_irq own", {31'd0, rx_irq[p]}, 32'd0);
                rd(1'(p), stat_of(p), v); chk("R2 R5 own stat", v, e);
                rd(1'(1-p), stat_of(p), v); chk("R8 peer reads stat", v, e);
                rd(1'(p), stat_of(1-p), v); chk("R3 other stat untouched", v, 32'd0);
                wr(1'(1-p), cmd_of(1-p), 32'd1 << n);
                chk("R11 pulse", {31'd0, txf_seen[p]}, {31'd0, (n < NCH)});
                @(negedge clk);
                chk("R11 pulse one cycle", {30'd0, tx_free}, 32'd0);
                rd(1'(p), stat_of(p), v); chk("R3 freed", v, 32'd0);
            end
        end

        // R3 R11 R10 full pattern sweep on processor 0, freed by processor 1
        for (int pat = 0; pat < (1 << NCH); pat++) begin
            logic [31:0] mask, e;
            mask = 32'(((pat * 3) ^ 5)) & ALL;
            e    = 32'(pat) & ~mask;
            wr(0, cmd_of(0), 32'(pat) << 16);
            wr(1, cmd_of(1), mask);
            chk("R11 pattern pulse", {31'd0, txf_seen[0]}, {31'd0, ((32'(pat) & mask) != 0)});
            chk("R10 pattern irq", {31'd0, rx_irq[1]}, {31'd0, (e != 0)});
            rd(0, stat_of(0), v); chk("R3 pattern stat", v, e);
            wr(1, cmd_of(1), 32'h0000_FFFF);
        end

        // R4 zero bits have no effect, command word reads 0
        wr(1, cmd_of(1), 32'h15 << 16);
        wr(1, cmd_of(1), 32'd0);
        wr(0, cmd_of(0), 32'd0);
        rd(0, stat_of(1), v); chk("R4 zeros ignored", v, 32'h15);
        rd(1, cmd_of(1), v); chk("R4 cmd reads 0", v, 32'd0);
        rd(0, cmd_of(0), v); chk("R4 cmd0 reads 0", v, 32'd0);

        // R8 command writes from the wrong processor are dropped
        wr(0, cmd_of(1), 32'hFFFF_FFFF);
        wr(1, cmd_of(0), 32'hFFFF_FFFF);
        rd(1, stat_of(1), v); chk("R8 wrong cpu stat1", v, 32'h15);
        rd(1, stat_of(0), v); chk("R8 wrong cpu stat0", v, 32'd0);

        // R7 undefined offsets and status words ignore writes, read 0
        wr(0, 12'h004, 32'hFFFF_FFFF);
        wr(1, 12'h100, 32'hFFFF_FFFF);
        wr(0, stat_of(1), 32'hFFFF_FFFF);
        wr(1, stat_of(1), 32'h0000_0000);
        rd(0, stat_of(1), v); chk("R7 stat1 kept", v, 32'h15);
        rd(0, stat_of(0), v); chk("R7 stat0 kept", v, 32'd0);
        rd(0, 12'h004, v); chk("R7 undefined read", v, 32'd0);
        rd(1, 12'h3F4, v); chk("R7 undefined read high", v, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule